// File: doc/BRIEF.md
# Variable-Latency Pipeline Interlock Unit

This block is the decode-stage hazard checker for a single-issue, in-order pipeline built as one linear chain: fetch, decode, a run of execute stages and one write-back stage. Operation classes finish after different numbers of execute stages. Shorter operations ride through the remaining execute stages as no-ops, so every instruction still writes back in order from the same final stage. Every result can be forwarded to any later consumer as soon as it exists. The unit therefore holds decode only when an operand the decoded instruction needs has not been computed by the stage where that instruction needs it.

For every architectural register it keeps a countdown. There is one table for the integer file and one for the floating-point file. The countdown gives the cycles left until a pending value can be forwarded. When an instruction issues, its destination entry is loaded from the latency of its class. Every entry counts down by one each cycle, and that includes stalled cycles. The decode instruction presents a class, up to two source registers, an optional store-data register and an optional destination. Each source must be ready when the instruction enters the first execute stage. Store data is needed one stage later, when the store enters its memory stages. The unit drives a stall that holds fetch and decode. It also drives a bubble strobe that puts a no-op into the first execute stage, and an advance strobe that marks an issue.

Top module: `hazard_interlock`

## Requirements
- R1: advance is high exactly when decValid is high and stall is low. bubble is the inverse of advance, so a no-op enters the first execute stage whenever nothing issues.
- R2: Class codes are 0 integer, 1 load, 2 store, 3 branch, 4 float add, 5 float multiply, 6 float divide and 7 no-op. Results become forwardable after 1 stage for integer, 2 for divide, 3 for add and load, and 5 for multiply. A consumer placed directly behind a producer of latency L stalls L-1 cycles.
- R3: The store-data operand (stData*) is checked only for class 2. It is needed one stage later than the other sources, so directly behind a producer of latency L it stalls max(L-2,0) cycles.
- R4: The store address (source A of a store) and the sources of a branch (class 3) must be ready at the first execute stage, under the same rule as in R2.
- R5: Stall is asserted only while a used operand is not yet computed. Independent instructions never stall, and each instruction placed between producer and consumer removes one stall cycle.
- R6: A newer writer to a register replaces the older pending entry, so a consumer waits only for the newest writer.
- R7: Countdowns keep decrementing while stall is high. With several pending operands the stall lasts until the slowest one is ready. A consumer that arrives later waits only for the time that remains.
- R8: Integer register 0 never becomes pending, and an instruction with dstValid low creates no entry. Floating register 0 is tracked normally.
- R9: Each operand is looked up in the integer file when its Fp bit is 0 and in the floating file when it is 1. The two files never affect each other.
- R10: A synchronous reset clears all pending entries. stall is low during reset and right after it.
- R11: stall is never high while decValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| decValid | input | 1 | Decode stage holds an instruction |
| opClass | input | 3 | Operation class code (see R2) |
| srcAIdx | input | 5 | Source A register index |
| srcAFp | input | 1 | Source A is in the floating file |
| srcAUse | input | 1 | Source A is read |
| srcBIdx | input | 5 | Source B register index |
| srcBFp | input | 1 | Source B is in the floating file |
| srcBUse | input | 1 | Source B is read |
| stDataIdx | input | 5 | Store-data register index |
| stDataFp | input | 1 | Store data is in the floating file |
| stDataUse | input | 1 | Store data is read (class 2 only) |
| dstIdx | input | 5 | Destination register index |
| dstFp | input | 1 | Destination is in the floating file |
| dstValid | input | 1 | Instruction writes a destination |
| stall | output | 1 | Hold fetch and decode |
| bubble | output | 1 | Insert a no-op into the first execute stage |
| advance | output | 1 | Decode instruction issues this cycle |

## Verification
The bench builds the block with its default parameters: 32 registers per file and latencies of 1, 2, 3, 5 and 3 for integer, divide, add, multiply and memory. With these values every stall length from zero to four cycles can be reached. So can the one-stage slack of store data, which turns a divide-to-store pair into a stall-free case and an add-to-store pair into a single stall. The four-cycle multiply window is long enough to place intervening instructions, overlapping producers, overwriting writers and a reset inside a pending countdown.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    OP_INT    = 3'd0,
    OP_LOAD   = 3'd1,
    OP_STORE  = 3'd2,
    OP_BRANCH = 3'd3,
    OP_FADD   = 3'd4,
    OP_FMUL   = 3'd5,
    OP_FDIV   = 3'd6,
    OP_NOP    = 3'd7
  } opClass_e;

  // strobes from control to the countdown tables
  typedef struct packed {
    logic wrEn;
    logic wrFp;
  } ilkStrobes_t;

  function automatic int maxLatency(input int a, input int b, input int c,
                                    input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

  function automatic logic producesResult(input opClass_e op);
    return (op == OP_INT) || (op == OP_LOAD) || (op == OP_FADD) ||
           (op == OP_FMUL) || (op == OP_FDIV);
  endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
  import ilk_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5,
  parameter int CNT_W    = 3,
  parameter int LAT_INT  = 1,
  parameter int LAT_FDIV = 2,
  parameter int LAT_FADD = 3,
  parameter int LAT_FMUL = 5,
  parameter int LAT_MEM  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  ilkStrobes_t       strobes,
  input  opClass_e          opClass,
  input  logic [REG_W-1:0]  dstIdx,
  input  logic [REG_W-1:0]  srcAIdx,
  input  logic              srcAFp,
  input  logic [REG_W-1:0]  srcBIdx,
  input  logic              srcBFp,
  input  logic [REG_W-1:0]  stDataIdx,
  input  logic              stDataFp,
  output logic [CNT_W-1:0]  cntA,
  output logic [CNT_W-1:0]  cntB,
  output logic [CNT_W-1:0]  cntSt
);

  localparam int NUM_FILES = 2;

  logic [CNT_W-1:0] cntTab [NUM_FILES][NUM_REGS];
  logic [CNT_W-1:0] wrCnt;
  int               classLat;

  // load value: cycles after next during which a next-stage reader must wait
  always_comb begin
    unique case (opClass)
      OP_INT:  classLat = LAT_INT;
      OP_LOAD: classLat = LAT_MEM;
      OP_FADD: classLat = LAT_FADD;
      OP_FMUL: classLat = LAT_FMUL;
      OP_FDIV: classLat = LAT_FDIV;
      default: classLat = 1;
    endcase
    wrCnt = CNT_W'(classLat - 1);
  end

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
      logic [CNT_W-1:0] q;
      logic             hit;

      assign hit = strobes.wrEn && (strobes.wrFp == (f == 1)) &&
                   (dstIdx == REG_W'(r));

      always_ff @(posedge clk) begin
        if (rst)
          q <= '0;
        else if (hit)
          q <= wrCnt;
        else if (q != '0)
          q <= q - 1'b1;
      end

      assign cntTab[f][r] = q;
    end
  end

  assign cntA  = cntTab[srcAFp][srcAIdx];
  assign cntB  = cntTab[srcBFp][srcBIdx];
  assign cntSt = cntTab[stDataFp][stDataIdx];

endmodule

// File: rtl/ilk_control.sv
module ilk_control
  import ilk_pkg::*;
#(
  parameter int REG_W         = 5,
  parameter int CNT_W         = 3,
  parameter int ST_DATA_SLACK = 1
) (
  input  logic              rst,
  input  logic              decValid,
  input  opClass_e          opClass,
  input  logic              srcAUse,
  input  logic              srcBUse,
  input  logic              stDataUse,
  input  logic [REG_W-1:0]  dstIdx,
  input  logic              dstFp,
  input  logic              dstValid,
  input  logic [CNT_W-1:0]  cntA,
  input  logic [CNT_W-1:0]  cntB,
  input  logic [CNT_W-1:0]  cntSt,
  output ilkStrobes_t       strobes,
  output logic              stall,
  output logic              bubble,
  output logic              advance
);

  localparam logic [CNT_W-1:0] SLACK = CNT_W'(ST_DATA_SLACK);

  logic hazA;
  logic hazB;
  logic hazSt;
  logic hazard;
  logic isIntZero;

  // first execute stage needs: any nonzero countdown blocks
  assign hazA  = srcAUse && (cntA != '0);
  assign hazB  = srcBUse && (cntB != '0);
  // store data is read one stage later
  assign hazSt = (opClass == OP_STORE) && stDataUse && (cntSt > SLACK);

  assign hazard  = hazA || hazB || hazSt;
  assign stall   = !rst && decValid && hazard;
  assign advance = !rst && decValid && !hazard;
  assign bubble  = !advance;

  assign isIntZero = !dstFp && (dstIdx == '0);

  always_comb begin
    strobes      = '0;
    strobes.wrEn = advance && dstValid && producesResult(opClass) && !isIntZero;
    strobes.wrFp = dstFp;
  end

endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
  import ilk_pkg::*;
#(
  parameter int NUM_REGS      = 32,
  parameter int LAT_INT       = 1,
  parameter int LAT_FDIV      = 2,
  parameter int LAT_FADD      = 3,
  parameter int LAT_FMUL      = 5,
  parameter int LAT_MEM       = 3,
  parameter int ST_DATA_SLACK = 1,
  localparam int REG_W        = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             decValid,
  input  logic [2:0]       opClass,
  input  logic [REG_W-1:0] srcAIdx,
  input  logic             srcAFp,
  input  logic             srcAUse,
  input  logic [REG_W-1:0] srcBIdx,
  input  logic             srcBFp,
  input  logic             srcBUse,
  input  logic [REG_W-1:0] stDataIdx,
  input  logic             stDataFp,
  input  logic             stDataUse,
  input  logic [REG_W-1:0] dstIdx,
  input  logic             dstFp,
  input  logic             dstValid,
  output logic             stall,
  output logic             bubble,
  output logic             advance
);

  localparam int MAX_LAT = maxLatency(LAT_INT, LAT_FDIV, LAT_FADD, LAT_FMUL, LAT_MEM);
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  opClass_e         opCls;
  ilkStrobes_t      strobes;
  logic [CNT_W-1:0] cntA;
  logic [CNT_W-1:0] cntB;
  logic [CNT_W-1:0] cntSt;

  assign opCls = opClass_e'(opClass);

  ilk_scoreboard #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .CNT_W    (CNT_W),
    .LAT_INT  (LAT_INT),
    .LAT_FDIV (LAT_FDIV),
    .LAT_FADD (LAT_FADD),
    .LAT_FMUL (LAT_FMUL),
    .LAT_MEM  (LAT_MEM)
  ) u_scoreboard (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .opClass   (opCls),
    .dstIdx    (dstIdx),
    .srcAIdx   (srcAIdx),
    .srcAFp    (srcAFp),
    .srcBIdx   (srcBIdx),
    .srcBFp    (srcBFp),
    .stDataIdx (stDataIdx),
    .stDataFp  (stDataFp),
    .cntA      (cntA),
    .cntB      (cntB),
    .cntSt     (cntSt)
  );

  ilk_control #(
    .REG_W         (REG_W),
    .CNT_W         (CNT_W),
    .ST_DATA_SLACK (ST_DATA_SLACK)
  ) u_control (
    .rst       (rst),
    .decValid  (decValid),
    .opClass   (opCls),
    .srcAUse   (srcAUse),
    .srcBUse   (srcBUse),
    .stDataUse (stDataUse),
    .dstIdx    (dstIdx),
    .dstFp     (dstFp),
    .dstValid  (dstValid),
    .cntA      (cntA),
    .cntB      (cntB),
    .cntSt     (cntSt),
    .strobes   (strobes),
    .stall     (stall),
    .bubble    (bubble),
    .advance   (advance)
  );

endmodule

// File: rtl/hazard_interlock_check.sv
module hazard_interlock_check #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             decValid,
  input logic [2:0]       opClass,
  input logic [REG_W-1:0] srcAIdx,
  input logic             srcAFp,
  input logic             srcAUse,
  input logic             srcBUse,
  input logic [REG_W-1:0] stDataIdx,
  input logic             stDataFp,
  input logic             stDataUse,
  input logic [REG_W-1:0] dstIdx,
  input logic             dstFp,
  input logic             dstValid,
  input logic             stall,
  input logic             bubble,
  input logic             advance
);

  AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    stall |-> decValid); // R11

  AST_STALL_HOLDS_DECODE: assert property (@(posedge clk) disable iff (rst)
    stall |-> (bubble && !advance)); // R1

  AST_FMUL_NEXT_STALLS: assert property (@(posedge clk) disable iff (rst)
    (advance && opClass == 3'd5 && dstValid && dstFp) |=>
    (!(decValid && srcAUse && srcAFp && srcAIdx == $past(dstIdx)) || stall)); // R2

  AST_LOAD_STDATA_STALLS: assert property (@(posedge clk) disable iff (rst)
    (advance && opClass == 3'd1 && dstValid && !dstFp && dstIdx != '0) |=>
    (!(decValid && opClass == 3'd2 && stDataUse && !stDataFp &&
       stDataIdx == $past(dstIdx)) || stall)); // R3

  AST_R0_NEVER_WAITS: assert property (@(posedge clk) disable iff (rst)
    (decValid && srcAUse && !srcAFp && srcAIdx == '0 && !srcBUse &&
     opClass != 3'd2) |-> !stall); // R8

  AST_STALL_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !stall); // R10

endmodule

bind hazard_interlock hazard_interlock_check #(.REG_W(REG_W)) u_check (
  .clk       (clk),
  .rst       (rst),
  .decValid  (decValid),
  .opClass   (opClass),
  .srcAIdx   (srcAIdx),
  .srcAFp    (srcAFp),
  .srcAUse   (srcAUse),
  .srcBUse   (srcBUse),
  .stDataIdx (stDataIdx),
  .stDataFp  (stDataFp),
  .stDataUse (stDataUse),
  .dstIdx    (dstIdx),
  .dstFp     (dstFp),
  .dstValid  (dstValid),
  .stall     (stall),
  .bubble    (bubble),
  .advance   (advance)
);

// File: tb/hazard_interlock_bench.sv
module hazard_interlock_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam logic [2:0] C_INT = 3'd0, C_LOAD = 3'd1, C_STORE = 3'd2,
                         C_BRANCH = 3'd3, C_FADD = 3'd4, C_FMUL = 3'd5,
                         C_FDIV = 3'd6;

  logic       clk = 1'b0;
  logic       rst;
  logic       decValid;
  logic [2:0] opClass;
  logic [4:0] srcAIdx, srcBIdx, stDataIdx, dstIdx;
  logic       srcAFp, srcAUse, srcBFp, srcBUse, stDataFp, stDataUse;
  logic       dstFp, dstValid;
  logic       stall, bubble, advance;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hazard_interlock u_hazard_interlock (
    .clk (clk), .rst (rst), .decValid (decValid), .opClass (opClass),
    .srcAIdx (srcAIdx), .srcAFp (srcAFp), .srcAUse (srcAUse),
    .srcBIdx (srcBIdx), .srcBFp (srcBFp), .srcBUse (srcBUse),
    .stDataIdx (stDataIdx), .stDataFp (stDataFp), .stDataUse (stDataUse),
    .dstIdx (dstIdx), .dstFp (dstFp), .dstValid (dstValid),
    .stall (stall), .bubble (bubble), .advance (advance)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearIns();
    decValid = 1'b1; opClass = C_INT;
    srcAIdx = 5'd0; srcAFp = 1'b0; srcAUse = 1'b0;
    srcBIdx = 5'd0; srcBFp = 1'b0; srcBUse = 1'b0;
    stDataIdx = 5'd0; stDataFp = 1'b0; stDataUse = 1'b0;
    dstIdx = 5'd0; dstFp = 1'b0; dstValid = 1'b0;
  endtask

  task automatic setProd(input logic [2:0] op, input logic [4:0] d, input logic fp);
    clearIns();
    opClass = op; dstIdx = d; dstFp = fp; dstValid = 1'b1;
  endtask

  task automatic setCons(input logic [2:0] op, input logic [4:0] a, input logic fp);
    clearIns();
    opClass = op; srcAIdx = a; srcAFp = fp; srcAUse = 1'b1;
  endtask

  task automatic setStore(input logic [4:0] s, input logic fp);
    clearIns();
    opClass = C_STORE; stDataIdx = s; stDataFp = fp; stDataUse = 1'b1;
  endtask

  // called at a negedge with inputs set; returns at the negedge after issue
  task automatic issueCount(output int n);
    n = 0;
    #1;
    while (stall && n < 50) begin
      n++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
  endtask

  task automatic drain();
    decValid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic pairStalls(input logic [2:0] pOp, input logic [4:0] d, input logic pFp,
                            input logic [2:0] cOp, input logic cFp, output int n);
    int dummy;
    setProd(pOp, d, pFp);
    issueCount(dummy);
    setCons(cOp, d, cFp);
    issueCount(n);
  endtask

  task automatic t_reset();
    int n;
    @(negedge clk);
    rst = 1'b1; clearIns(); srcAUse = 1'b1;
    @(negedge clk); #1;
    check("R10 stall low in reset", int'(stall), 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R10 stall low after reset", int'(stall), 0);
    @(negedge clk);
    drain();
    setProd(C_FMUL, 5'd2, 1'b1); issueCount(n);
    rst = 1'b1; decValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    setCons(C_FADD, 5'd2, 1'b1); issueCount(n);
    check("R10 reset clears pending", n, 0);
    drain();
  endtask

  task automatic t_latency();
    int n;
    pairStalls(C_INT, 5'd3, 1'b0, C_INT, 1'b0, n);   check("R2 int->use", n, 0); drain();
    pairStalls(C_FDIV, 5'd3, 1'b1, C_FADD, 1'b1, n); check("R2 fdiv->use", n, 1); drain();
    pairStalls(C_FADD, 5'd3, 1'b1, C_FMUL, 1'b1, n); check("R2 fadd->use", n, 2); drain();
    pairStalls(C_FMUL, 5'd3, 1'b1, C_FADD, 1'b1, n); check("R2 fmul->use", n, 4); drain();
    pairStalls(C_LOAD, 5'd4, 1'b0, C_INT, 1'b0, n);  check("R2 load->use", n, 2); drain();
  endtask

  task automatic t_store();
    int n, dummy;
    setProd(C_FMUL, 5'd6, 1'b1); issueCount(dummy);
    setStore(5'd6, 1'b1); issueCount(n); check("R3 fmul->stdata", n, 3); drain();
    setProd(C_FADD, 5'd6, 1'b1); issueCount(dummy);
    setStore(5'd6, 1'b1); issueCount(n); check("R3 fadd->stdata", n, 1); drain();
    setProd(C_FDIV, 5'd6, 1'b1); issueCount(dummy);
    setStore(5'd6, 1'b1); issueCount(n); check("R3 fdiv->stdata", n, 0); drain();
    setProd(C_LOAD, 5'd7, 1'b0); issueCount(dummy);
    setStore(5'd7, 1'b0); issueCount(n); check("R3 load->stdata", n, 1); drain();
    pairStalls(C_LOAD, 5'd8, 1'b0, C_STORE, 1'b0, n); check("R4 load->store addr", n, 2); drain();
    pairStalls(C_LOAD, 5'd9, 1'b0, C_BRANCH, 1'b0, n); check("R4 load->branch", n, 2); drain();
  endtask

  task automatic t_distance();
    int n, dummy;
    setProd(C_FMUL, 5'd10, 1'b1); issueCount(dummy);
    setProd(C_INT, 5'd1, 1'b0); issueCount(n); check("R5 independent no stall", n, 0);
    setCons(C_FADD, 5'd10, 1'b1); issueCount(n); check("R5 one gap", n, 3); drain();
  endtask

  task automatic t_overwrite();
    int n, dummy;
    setProd(C_FMUL, 5'd12, 1'b1); issueCount(dummy);
    setProd(C_FDIV, 5'd12, 1'b1); issueCount(dummy);
    setCons(C_FADD, 5'd12, 1'b1); issueCount(n); check("R6 newest writer", n, 1); drain();
  endtask

  task automatic t_countdown();
    int n, dummy;
    setProd(C_FMUL, 5'd1, 1'b1); issueCount(dummy);
    setProd(C_FMUL, 5'd2, 1'b1); issueCount(dummy);
    clearIns(); opClass = C_FADD;
    srcAIdx = 5'd1; srcAFp = 1'b1; srcAUse = 1'b1;
    srcBIdx = 5'd2; srcBFp = 1'b1; srcBUse = 1'b1;
    issueCount(n); check("R7 slowest operand", n, 4); drain();
    setProd(C_FMUL, 5'd1, 1'b1); issueCount(dummy);
    setCons(C_FADD, 5'd1, 1'b1); issueCount(n); check("R7 first consumer", n, 4);
    setCons(C_FADD, 5'd1, 1'b1); issueCount(n); check("R7 counted during stall", n, 0);
    drain();
  endtask

  task automatic t_zero();
    int n, dummy;
    pairStalls(C_INT, 5'd0, 1'b0, C_INT, 1'b0, n);  check("R8 int r0 int op", n, 0); drain();
    pairStalls(C_LOAD, 5'd0, 1'b0, C_INT, 1'b0, n); check("R8 int r0 load", n, 0); drain();
    setProd(C_FMUL, 5'd5, 1'b1); dstValid = 1'b0; issueCount(dummy);
    setCons(C_FADD, 5'd5, 1'b1); issueCount(n); check("R8 no dest no entry", n, 0); drain();
    pairStalls(C_FMUL, 5'd0, 1'b1, C_FADD, 1'b1, n); check("R8 fp f0 tracked", n, 4); drain();
  endtask

  task automatic t_files();
    int n;
    pairStalls(C_LOAD, 5'd5, 1'b0, C_FADD, 1'b1, n); check("R9 int vs fp", n, 0); drain();
    pairStalls(C_FMUL, 5'd6, 1'b1, C_INT, 1'b0, n);  check("R9 fp vs int", n, 0); drain();
  endtask

  task automatic t_strobes();
    int dummy;
    setProd(C_FMUL, 5'd1, 1'b1); issueCount(dummy);
    setCons(C_FADD, 5'd1, 1'b1); decValid = 1'b0;
    #1;
    check("R11 no stall when decode empty", int'(stall), 0);
    check("R1 bubble when decode empty", int'(bubble), 1);
    check("R1 no advance when decode empty", int'(advance), 0);
    @(negedge clk);
    decValid = 1'b1;
    #1;
    check("R1 stall seen", int'(stall), 1);
    check("R1 bubble during stall", int'(bubble), 1);
    check("R1 no advance during stall", int'(advance), 0);
    repeat (4) @(negedge clk);
    #1;
    check("R1 advance on issue", int'(advance), 1);
    check("R1 no bubble on issue", int'(bubble), 0);
    @(negedge clk);
    drain();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clearIns(); decValid = 1'b0; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_store();
    t_distance();
    t_overwrite();
    t_countdown();
    t_zero();
    t_files();
    t_strobes();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule